// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the host-visible register file of one descriptor-driven DMA/XOR channel. A host issues single-cycle 32-bit register writes and reads over a simple address/data port. The block holds the channel's run state and the address of the next descriptor to fetch. It turns host writes into one-cycle command pulses for the transfer engine: start, stop and append. It also collects the engine's completion and error strobes into sticky status flags.

Software enables the channel to start processing a chain and clears the enable to stop it. When it has linked new descriptors behind the last one, it sets the append bit, and the engine re-reads that descriptor's link field. The engine reports its activity through a live busy level and its current descriptor address. It reports events through single-cycle strobes. Each event becomes a sticky flag, and software clears the flags one at a time by writing ones. The interrupt line stays high while any flag is set.

Register reads are combinational: `host_rdata` reflects `host_addr` in the same cycle. Register writes take effect at the clock edge.

Top module: `dma_chan_csr`

## Requirements
- R1: After synchronous reset, the control register, the next-descriptor register and every status flag read 0. `irq`, `eng_start`, `eng_stop` and `eng_append` are low.
- R2: A write to offset 0x00 with bit 0 set, while the enable bit is clear, raises `eng_start` for exactly the one cycle after the write. Bit 0 of offset 0x00 then reads 1.
- R3: A write to offset 0x00 with bit 0 clear, while the enable bit is set, raises `eng_stop` for exactly the one cycle after the write. A write that leaves bit 0 unchanged produces neither pulse.
- R4: A write to offset 0x00 with bit 1 set raises `eng_append` for the one cycle after the write. During that cycle bit 1 of offset 0x00 reads 1. Without a further such write, bit 1 reads 0 and `eng_append` is low from the next cycle on.
- R5: Offset 0x24 is a 32-bit read/write register holding the next descriptor address. Its value drives `eng_next_desc`.
- R6: Offset 0x08 returns `eng_cur_desc` as it is in that cycle. Writes to offset 0x08 change no register.
- R7: Bit 13 of offset 0x04 reads `eng_busy` as it is in that cycle. Writing to it has no effect.
- R8: An engine strobe sets a sticky flag at offset 0x04, readable in the cycle after the strobe. The flags sit at these bit positions: end of transfer at bit 12, end of chain at bit 11, internal parity error at bit 9, memory-controller abort at bit 5, target abort at bit 4, master abort at bit 3. All other bits of offset 0x04 read 0.
- R9: A write to offset 0x04 clears exactly those flags whose bit position carries a 1. Zero bits leave their flags unchanged.
- R10: When a strobe and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when at least one status flag is set.
- R12: Reads of any offset other than 0x00, 0x04, 0x08 and 0x24 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe for this cycle |
| host_addr | input | ADDR_W | Byte offset of the accessed register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| eng_start | output | 1 | One-cycle pulse: begin processing the chain |
| eng_stop | output | 1 | One-cycle pulse: halt the channel |
| eng_append | output | 1 | One-cycle pulse: re-read the last descriptor's link |
| eng_next_desc | output | 32 | Next descriptor address register value |
| eng_cur_desc | input | 32 | Address of the descriptor the engine is working on |
| eng_busy | input | 1 | Engine activity level |
| eng_eot | input | 1 | End-of-transfer strobe |
| eng_eoc | input | 1 | End-of-chain strobe |
| eng_err_parity | input | 1 | Internal parity error strobe |
| eng_err_memctl | input | 1 | Memory-controller abort strobe |
| eng_err_tgt_abort | input | 1 | Target abort strobe |
| eng_err_mst_abort | input | 1 | Master abort strobe |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
On every cycle, the embedded properties check the following:
- Each command pulse matches the enable state it leaves behind.
- The append pulse drops after one cycle.
- The next-descriptor register only moves on a write.
- Every flag sets after its strobe, holds until a write-one clear, and stays set when strobe and clear collide.
- The interrupt rises only after a strobe.

Only the bench's scenarios can show that the read multiplexer exposes the right bit positions. The same holds for these behaviours:
- unmapped offsets read zero;
- writes to the busy bit and the current-descriptor offset change nothing;
- re-writing the same enable value produces no pulse.

The bench shows these by comparing every output with its behavioural model on each clock.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_FLAGS = 6;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_CUR  = 'h08;
    localparam int OFS_NEXT = 'h24;

    localparam int BIT_EN   = 0;
    localparam int BIT_APP  = 1;
    localparam int BIT_BUSY = 13;

    // flag index: 0 eot, 1 eoc, 2 parity, 3 memctl, 4 tgt abort, 5 mst abort
    localparam int FLAG_POS [NUM_FLAGS] = '{12, 11, 9, 5, 4, 3};

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CUR,
        SEL_NEXT
    } reg_sel_e;

    typedef struct packed {
        logic app;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
    } eng_cmd_t;

    function automatic reg_sel_e decode_addr(logic [31:0] a);
        case (a)
            32'(OFS_CTRL): return SEL_CTRL;
            32'(OFS_STAT): return SEL_STAT;
            32'(OFS_CUR):  return SEL_CUR;
            32'(OFS_NEXT): return SEL_NEXT;
            default:       return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
    import dcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [1:0]        wr_bits,
    input  logic              wr_next,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output eng_cmd_t          cmd,
    output logic [DATA_W-1:0] next_desc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cmd  <= '0;
        end else if (wr_ctrl) begin
            ctrl.en   <= wr_bits[BIT_EN];
            ctrl.app  <= wr_bits[BIT_APP];
            cmd.start <= wr_bits[BIT_EN] & ~ctrl.en;
            cmd.stop  <= ~wr_bits[BIT_EN] & ctrl.en;
        end else begin
            ctrl.app <= 1'b0;
            cmd      <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            next_desc <= '0;
        else if (wr_next)
            next_desc <= wdata;
    end

    AST_START_ENABLED: assert property (@(posedge clk) disable iff (rst)
        cmd.start |-> ctrl.en); // R2
    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmd.start |-> $past(wr_ctrl)); // R2
    AST_STOP_DISABLED: assert property (@(posedge clk) disable iff (rst)
        cmd.stop |-> !ctrl.en); // R3
    AST_APPEND_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctrl.app && !(wr_ctrl && wr_bits[BIT_APP])) |=> !ctrl.app); // R4
    AST_NEXT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_next |=> $stable(next_desc)); // R5

endmodule

// File: rtl/dcc_status.sv
module dcc_status
    import dcc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FLAGS-1:0] ev,
    input  logic [NUM_FLAGS-1:0] clr,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (ev[i])
                flags[i] <= 1'b1;
            else if (clr[i])
                flags[i] <= 1'b0;
        end

        AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> flags[i]); // R8
        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (ev[i] && clr[i]) |=> flags[i]); // R10
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr[i]) |=> flags[i]); // R9
        AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !ev[i]) |=> !flags[i]); // R9
    end

    assign irq = |flags;

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|ev)); // R11

endmodule

// File: rtl/dcc_rdmux.sv
module dcc_rdmux
    import dcc_pkg::*;
(
    input  reg_sel_e             sel,
    input  ctrl_t                ctrl,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic                 busy,
    input  logic [DATA_W-1:0]    cur_desc,
    input  logic [DATA_W-1:0]    next_desc,
    output logic [DATA_W-1:0]    rdata
);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: begin
                rdata[BIT_EN]  = ctrl.en;
                rdata[BIT_APP] = ctrl.app;
            end
            SEL_STAT: begin
                rdata[BIT_BUSY] = busy;
                for (int i = 0; i < NUM_FLAGS; i++)
                    rdata[FLAG_POS[i]] = flags[i];
            end
            SEL_CUR:  rdata = cur_desc;
            SEL_NEXT: rdata = next_desc;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dcc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              eng_start,
    output logic              eng_stop,
    output logic              eng_append,
    output logic [31:0]       eng_next_desc,
    input  logic [31:0]       eng_cur_desc,
    input  logic              eng_busy,
    input  logic              eng_eot,
    input  logic              eng_eoc,
    input  logic              eng_err_parity,
    input  logic              eng_err_memctl,
    input  logic              eng_err_tgt_abort,
    input  logic              eng_err_mst_abort,
    output logic              irq
);

    reg_sel_e             sel;
    ctrl_t                ctrl;
    eng_cmd_t             cmd;
    logic [NUM_FLAGS-1:0] ev;
    logic [NUM_FLAGS-1:0] clr;
    logic [NUM_FLAGS-1:0] flags;
    logic                 wr_stat;

    assign sel     = decode_addr(32'(host_addr));
    assign wr_stat = host_wr && (sel == SEL_STAT);
    assign ev      = {eng_err_mst_abort, eng_err_tgt_abort, eng_err_memctl,
                      eng_err_parity, eng_eoc, eng_eot};

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
        assign clr[i] = wr_stat & host_wdata[FLAG_POS[i]];
    end

    dcc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (host_wr && (sel == SEL_CTRL)),
        .wr_bits   (host_wdata[1:0]),
        .wr_next   (host_wr && (sel == SEL_NEXT)),
        .wdata     (host_wdata),
        .ctrl      (ctrl),
        .cmd       (cmd),
        .next_desc (eng_next_desc)
    );

    dcc_status u_status (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .clr   (clr),
        .flags (flags),
        .irq   (irq)
    );

    dcc_rdmux u_rdmux (
        .sel       (sel),
        .ctrl      (ctrl),
        .flags     (flags),
        .busy      (eng_busy),
        .cur_desc  (eng_cur_desc),
        .next_desc (eng_next_desc),
        .rdata     (host_rdata)
    );

    assign eng_start  = cmd.start;
    assign eng_stop   = cmd.stop;
    assign eng_append = ctrl.app;

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(eng_start && eng_stop)); // R3

endmodule

// File: tb/dma_chan_csr_bench.sv
module dma_chan_csr_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr;
    logic [5:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        eng_start, eng_stop, eng_append, irq;
    logic [31:0] eng_next_desc;
    logic [31:0] eng_cur_desc;
    logic        eng_busy;
    logic [5:0]  ev;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // behavioural model state
    bit          m_en, m_app, m_start, m_stop;
    logic [31:0] m_next;
    bit          m_fl [6];
    int          POS  [6] = '{12, 11, 9, 5, 4, 3};

    always #2 clk = ~clk;

    dma_chan_csr u_dma_chan_csr (
        .clk               (clk),
        .rst               (rst),
        .host_wr           (host_wr),
        .host_addr         (host_addr),
        .host_wdata        (host_wdata),
        .host_rdata        (host_rdata),
        .eng_start         (eng_start),
        .eng_stop          (eng_stop),
        .eng_append        (eng_append),
        .eng_next_desc     (eng_next_desc),
        .eng_cur_desc      (eng_cur_desc),
        .eng_busy          (eng_busy),
        .eng_eot           (ev[0]),
        .eng_eoc           (ev[1]),
        .eng_err_parity    (ev[2]),
        .eng_err_memctl    (ev[3]),
        .eng_err_tgt_abort (ev[4]),
        .eng_err_mst_abort (ev[5]),
        .irq               (irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd();
        logic [31:0] r = '0;
        case (int'(host_addr))
            'h00: begin r[0] = m_en; r[1] = m_app; end
            'h04: begin
                r[13] = eng_busy;
                foreach (POS[k]) r[POS[k]] = m_fl[k];
            end
            'h08: r = eng_cur_desc;
            'h24: r = m_next;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic bit model_irq();
        bit any = 0;
        foreach (m_fl[k]) any |= m_fl[k];
        return any;
    endfunction

    task automatic model_step();
        if (rst) begin
            m_en = 0; m_app = 0; m_start = 0; m_stop = 0; m_next = '0;
            foreach (m_fl[k]) m_fl[k] = 0;
        end else begin
            m_start = 0; m_stop = 0; m_app = 0;
            if (host_wr && host_addr == 6'h00) begin
                m_start = host_wdata[0] && !m_en;
                m_stop  = !host_wdata[0] && m_en;
                m_en    = host_wdata[0];
                m_app   = host_wdata[1];
            end
            if (host_wr && host_addr == 6'h24) m_next = host_wdata;
            foreach (m_fl[k]) begin
                if (ev[k]) m_fl[k] = 1;
                else if (host_wr && host_addr == 6'h04 && host_wdata[POS[k]]) m_fl[k] = 0;
            end
        end
    endtask

    task automatic compare_all();
        string rq;
        case (int'(host_addr))
            'h00: rq = "R2/R4 ctrl read";
            'h04: rq = "R8 status read";
            'h08: rq = "R6 cur desc read";
            'h24: rq = "R5 next desc read";
            default: rq = "R12 unmapped read";
        endcase
        chk(rq, host_rdata, model_rd());
        chk("R2 eng_start", 32'(eng_start), 32'(m_start));
        chk("R3 eng_stop", 32'(eng_stop), 32'(m_stop));
        chk("R4 eng_append", 32'(eng_append), 32'(m_app));
        chk("R5 eng_next_desc", eng_next_desc, m_next);
        chk("R11 irq", 32'(irq), 32'(model_irq()));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        cyc();
        host_wr = 0;
    endtask

    task automatic rd(logic [5:0] a);
        host_addr = a;
        cyc();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; host_wr = 0; host_addr = '0; host_wdata = '0;
        eng_cur_desc = '0; eng_busy = 0; ev = '0;
        repeat (3) cyc();
        rst = 0;

        // R1: reset state of every register and output
        rd(6'h00); chk("R1 ctrl", host_rdata, 32'h0);
        rd(6'h04); chk("R1 status", host_rdata, 32'h0);
        rd(6'h24); chk("R1 next", host_rdata, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 start, then R3 same value gives no pulse
        wr(6'h00, 32'h1);
        rd(6'h00); chk("R2 enable readback", host_rdata, 32'h1);
        wr(6'h00, 32'h1);
        chk("R3 no pulse on same value", 32'({eng_start, eng_stop}), 32'h0);

        // R4 append pulse and self-clear
        wr(6'h00, 32'h3);
        chk("R4 append visible", host_rdata, 32'h3);
        rd(6'h00); chk("R4 append cleared", host_rdata, 32'h1);
        wr(6'h00, 32'h3); wr(6'h00, 32'h3); rd(6'h00);

        // R5 next descriptor register
        wr(6'h24, 32'hDEAD_BEE0); rd(6'h24);
        chk("R5 next value", host_rdata, 32'hDEAD_BEE0);
        wr(6'h24, 32'h0000_1240); rd(6'h24);

        // R6 current descriptor is live, writes ignored
        eng_cur_desc = 32'h1234_5670; rd(6'h08);
        chk("R6 live cur", host_rdata, 32'h1234_5670);
        eng_cur_desc = 32'hCAFE_0100; rd(6'h08);
        wr(6'h08, 32'hFFFF_FFFF);
        rd(6'h24); chk("R6 write ignored", host_rdata, 32'h0000_1240);

        // R7 busy mirrors engine, writes have no effect
        eng_busy = 1; rd(6'h04);
        chk("R7 busy", host_rdata, 32'h0000_2000);
        wr(6'h04, 32'hFFFF_FFFF);
        chk("R7 busy after write", host_rdata, 32'h0000_2000);
        eng_busy = 0; rd(6'h04);

        // R8 each strobe individually, R9 individual clear
        for (int k = 0; k < 6; k++) begin
            ev = 6'(1 << k); host_addr = 6'h04; cyc(); ev = '0;
            chk("R8 flag set", host_rdata, 32'(1) << POS[k]);
            wr(6'h04, 32'h0);
            chk("R9 zero write keeps flag", host_rdata, 32'(1) << POS[k]);
            wr(6'h04, 32'(1) << POS[k]);
            chk("R9 flag cleared", host_rdata, 32'h0);
        end

        // R9 selective clear among several flags, R11 irq
        ev = 6'b111111; host_addr = 6'h04; cyc(); ev = '0;
        chk("R11 irq high", 32'(irq), 32'h1);
        wr(6'h04, 32'h0000_1000 | 32'h0000_0020);
        chk("R9 selective", host_rdata, 32'h0000_0A18);
        wr(6'h04, 32'hFFFF_FFFF);
        chk("R11 irq low", 32'(irq), 32'h0);

        // R10 set wins over same-cycle clear
        ev = 6'b000010; wr(6'h04, 32'h0000_0800); ev = '0;
        chk("R10 set wins", host_rdata, 32'h0000_0800);
        wr(6'h04, 32'h0000_0800);

        // R12 unmapped offsets
        rd(6'h0C); chk("R12 0x0C", host_rdata, 32'h0);
        rd(6'h28); chk("R12 0x28", host_rdata, 32'h0);
        rd(6'h3C); chk("R12 0x3C", host_rdata, 32'h0);

        // R3 stop pulse
        wr(6'h00, 32'h0);
        chk("R3 stop pulse", 32'(eng_stop), 32'h1);
        rd(6'h00); chk("R3 disabled", host_rdata, 32'h0);
        rd(6'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule